// File: doc/BRIEF.md
# Interleaved Multi-Bank Byte Memory

This block is a byte-wide memory split into a power-of-two number of equal banks. Each bank answers a read a fixed number of cycles after accepting it. By default the low address bits pick the bank, so neighbouring bytes sit in different banks. A requester can then start one read per clock on a run of consecutive addresses without waiting for earlier reads to come back. After the pipeline fills, a whole line of bytes streams out at one byte per cycle, in the order the reads were accepted.

A build-time parameter moves bank selection to the top address bits instead. In that mode a run of consecutive bytes stays in one bank, and each read in the run waits for the bank to finish the one before. Requests follow a valid/ready handshake. A request that targets a busy bank is held off until the bank frees, so it is never dropped. A single-byte write uses the same request port. It returns no response and ties up its bank only in the cycle it is accepted.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: After reset, `req_ready` is high for every address and `rsp_valid` is low.
- R2: With `MAP = MAP_LOW`, the bank is `req_addr[BANK_BITS-1:0]` and the bank-local address is the remaining upper bits. A run of consecutive addresses is therefore accepted on consecutive cycles with no stall.
- R3: With `MAP = MAP_HIGH`, the bank is `req_addr[ADDR_W-1 -: BANK_BITS]` and the local address is the lower `ADDR_W-BANK_BITS` bits. Reads to two different banks are accepted on consecutive cycles.
- R4: A read accepted in cycle n raises `rsp_valid` in cycle n+LAT, with `rsp_data` equal to the byte last written at that address.
- R5: Responses leave in acceptance order, one per cycle, when reads are accepted on consecutive cycles.
- R6: After a bank accepts a read, `req_ready` is low for any request to that bank during the next LAT-1 cycles. The bank can accept again LAT cycles after the first acceptance.
- R7: A write (`req_we` = 1) is accepted only when its bank is idle. It stores `req_wdata` and produces no response. The bank can accept another request in the very next cycle.
- R8: A request held on the port while its bank is busy is accepted once the bank becomes idle, and its response carries the correct data.
- R9: With `MAP = MAP_HIGH`, two consecutive addresses map to the same bank. Back-to-back reads to them are therefore accepted LAT cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Target bank can take the request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 8 | Read data |

## Verification
On every cycle, the embedded properties check three things at each bank. A bank that took a read turns busy at once. It never sees an access while busy. A lone write leaves it idle again. On every cycle they also check that requests reach at most one bank, and that every response is matched by an earlier accepted read with no more than LAT reads in flight.

Only the bench scenarios can show the following:
- the exact response cycle;
- the returned byte values;
- the ordering across a full line fill;
- the stall length for a repeat hit on one bank;
- how each mapping mode places addresses into banks.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    typedef logic [7:0] byte_t;

    // Which address bits choose the bank.
    typedef enum logic {
        MAP_LOW  = 1'b0,
        MAP_HIGH = 1'b1
    } map_e;
endpackage

// File: rtl/ilv_addr_split.sv
module ilv_addr_split
    import ilv_pkg::*;
#(
    parameter int   ADDR_W    = 10,
    parameter int   BANK_BITS = 3,
    parameter map_e MAP       = MAP_LOW,
    localparam int  LOC_W     = ADDR_W - BANK_BITS
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [BANK_BITS-1:0] bank,
    output logic [LOC_W-1:0]     loc
);
    timeunit 1ns;
    timeprecision 100ps;

    generate
        if (MAP == MAP_LOW) begin : g_low
            // Bank = address modulo bank count.
            assign bank = addr[BANK_BITS-1:0];
            assign loc  = addr[ADDR_W-1:BANK_BITS];
        end else begin : g_high
            // Bank = top bits, contiguous regions per bank.
            assign bank = addr[ADDR_W-1 -: BANK_BITS];
            assign loc  = addr[LOC_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank
    import ilv_pkg::*;
#(
    parameter int  LOC_W = 7,
    parameter int  LAT   = 8,
    localparam int DEPTH = 1 << LOC_W,
    localparam int CNT_W = $clog2(LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [LOC_W-1:0] loc,
    input  byte_t            wdata,
    output byte_t            rdata,
    output logic             idle
);
    timeunit 1ns;
    timeprecision 100ps;

    typedef struct packed {
        logic [CNT_W-1:0] busy_cnt;
    } bank_st_t;

    bank_st_t st_d, st_q;
    byte_t    mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            st_d.busy_cnt = CNT_W'(LAT - 1);
        end else if (st_q.busy_cnt != '0) begin
            st_d.busy_cnt = st_q.busy_cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[loc] <= wdata;
        end
    end

    // Array is sampled at accept time; the bank stays locked until the answer leaves.
    assign rdata = mem_q[loc];
    assign idle  = (st_q.busy_cnt == '0);

    generate
        if (LAT > 1) begin : g_busy_chk
            // R6
            read_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rd_en |=> !idle);
        end
    endgenerate

    // R7
    no_access_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> !(rd_en || wr_en));

    // R7
    write_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en) |=> idle);
endmodule

// File: rtl/ilv_rsp_pipe.sv
module ilv_rsp_pipe
    import ilv_pkg::*;
#(
    parameter int LAT = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_vld,
    input  byte_t in_data,
    output logic  out_vld,
    output byte_t out_data
);
    timeunit 1ns;
    timeprecision 100ps;

    typedef struct packed {
        logic  [LAT-1:0] vld;
        byte_t [LAT-1:0] dat;
    } pipe_st_t;

    pipe_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.vld[0] = in_vld;
        st_d.dat[0] = in_data;
        for (int i = 1; i < LAT; i++) begin
            st_d.vld[i] = st_q.vld[i-1];
            st_d.dat[i] = st_q.dat[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld  = st_q.vld[LAT-1];
    assign out_data = st_q.dat[LAT-1];
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl
    import ilv_pkg::*;
#(
    parameter int   ADDR_W    = 10,
    parameter int   BANK_BITS = 3,
    parameter int   LAT       = 8,
    parameter map_e MAP       = MAP_LOW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic              rsp_valid,
    output logic [7:0]        rsp_data
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NBANK = 1 << BANK_BITS;
    localparam int LOC_W = ADDR_W - BANK_BITS;
    localparam int OUT_W = $clog2(LAT + 2);

    logic [BANK_BITS-1:0] bank_sel;
    logic [LOC_W-1:0]     loc;
    logic [NBANK-1:0]     bank_idle;
    logic [NBANK-1:0]     rd_en;
    logic [NBANK-1:0]     wr_en;
    byte_t                bank_rdata [NBANK];
    logic                 rd_accept;

    ilv_addr_split #(
        .ADDR_W    (ADDR_W),
        .BANK_BITS (BANK_BITS),
        .MAP       (MAP)
    ) i_split (
        .addr (req_addr),
        .bank (bank_sel),
        .loc  (loc)
    );

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            ilv_bank #(
                .LOC_W (LOC_W),
                .LAT   (LAT)
            ) i_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .rd_en (rd_en[b]),
                .wr_en (wr_en[b]),
                .loc   (loc),
                .wdata (req_wdata),
                .rdata (bank_rdata[b]),
                .idle  (bank_idle[b])
            );
        end
    endgenerate

    always_comb begin
        rd_en     = '0;
        wr_en     = '0;
        req_ready = bank_idle[bank_sel];
        if (req_valid && req_ready) begin
            if (req_we) begin
                wr_en[bank_sel] = 1'b1;
            end else begin
                rd_en[bank_sel] = 1'b1;
            end
        end
    end

    assign rd_accept = req_valid && req_ready && !req_we;

    ilv_rsp_pipe #(
        .LAT (LAT)
    ) i_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (rd_accept),
        .in_data  (bank_rdata[bank_sel]),
        .out_vld  (rsp_valid),
        .out_data (rsp_data)
    );

    // Count of accepted reads not yet answered, kept only for the properties below.
    logic [OUT_W-1:0] outst_d, outst_q;

    always_comb begin
        outst_d = outst_q;
        if (rd_accept && !rsp_valid) begin
            outst_d = outst_q + OUT_W'(1);
        end else if (!rd_accept && rsp_valid) begin
            outst_d = outst_q - OUT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= '0;
        end else begin
            outst_q <= outst_d;
        end
    end

    // R4
    rsp_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (outst_q != '0));

    // R5
    inflight_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q <= OUT_W'(LAT));

    // R2
    one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_en | wr_en));
endmodule

// File: tb/test_ilv_mem_ctrl.sv
module test_ilv_mem_ctrl;
    import ilv_pkg::*;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int AW  = 10;
    localparam int LAT = 8;

    // Point-read vectors: {address, expected byte} after the preload pattern.
    localparam int VEC [6][2] = '{
        '{0, 11}, '{5, 196}, '{13, 236}, '{22, 57}, '{47, 214}, '{63, 38}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic          lo_valid = 1'b0, lo_we = 1'b0;
    logic [AW-1:0] lo_addr = '0;
    logic [7:0]    lo_wdata = '0;
    logic          lo_ready, lo_rsp_valid;
    logic [7:0]    lo_rsp_data;

    logic          hi_valid = 1'b0, hi_we = 1'b0;
    logic [AW-1:0] hi_addr = '0;
    logic [7:0]    hi_wdata = '0;
    logic          hi_ready, hi_rsp_valid;
    logic [7:0]    hi_rsp_data;

    int cyc = 0;
    int total = 0;
    int fails = 0;
    int lo_qc[$];
    int lo_qd[$];
    int hi_qc[$];
    int hi_qd[$];

    always #2.5 clk = ~clk;

    ilv_mem_ctrl #(.ADDR_W(AW), .BANK_BITS(3), .LAT(LAT), .MAP(MAP_LOW)) i_ilv_mem_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(lo_valid), .req_ready(lo_ready),
        .req_we(lo_we), .req_addr(lo_addr), .req_wdata(lo_wdata),
        .rsp_valid(lo_rsp_valid), .rsp_data(lo_rsp_data));

    ilv_mem_ctrl #(.ADDR_W(AW), .BANK_BITS(3), .LAT(LAT), .MAP(MAP_HIGH)) i_ilv_mem_ctrl_hi (
        .clk(clk), .rst_n(rst_n), .req_valid(hi_valid), .req_ready(hi_ready),
        .req_we(hi_we), .req_addr(hi_addr), .req_wdata(hi_wdata),
        .rsp_valid(hi_rsp_valid), .rsp_data(hi_rsp_data));

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (lo_rsp_valid) begin lo_qc.push_back(cyc); lo_qd.push_back(int'(lo_rsp_data)); end
            if (hi_rsp_valid) begin hi_qc.push_back(cyc); hi_qd.push_back(int'(hi_rsp_data)); end
        end
    end

    function automatic int pat(int a);
        return (a * 37 + 11) & 255;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    task automatic issue(input bit hi, input int a, input bit w, input int d, output int acc);
        @(negedge clk);
        if (hi) begin hi_valid = 1'b1; hi_we = w; hi_addr = AW'(a); hi_wdata = 8'(d); end
        else    begin lo_valid = 1'b1; lo_we = w; lo_addr = AW'(a); lo_wdata = 8'(d); end
        #0.5;
        while (!(hi ? hi_ready : lo_ready)) begin
            @(negedge clk);
            #0.5;
        end
        acc = cyc;
        @(posedge clk);
        #0.2;
        lo_valid = 1'b0;
        hi_valid = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        report();
        $finish;
    end

    initial begin
        int a0, a1, a2, w0, w1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, every bank ready, nothing returned
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            lo_addr = AW'(i);
            hi_addr = AW'(i * 128);
            #0.5;
            chk(lo_ready == 1'b1 && hi_ready == 1'b1, "R1 ready", int'(lo_ready & hi_ready), 1);
        end
        chk(lo_rsp_valid == 1'b0 && hi_rsp_valid == 1'b0, "R1 rsp_valid", int'(lo_rsp_valid), 0);

        // R7: preload writes stream one per cycle with no response
        for (int i = 0; i < 64; i++) begin
            issue(1'b0, i, 1'b1, pat(i), a1);
            if (i == 0) a0 = a1;
        end
        chk(a1 - a0 == 63, "R7 write stream", a1 - a0, 63);
        idle_cycles(LAT + 2);
        chk(lo_qc.size() == 0, "R7 writes silent", lo_qc.size(), 0);

        // R4: table-driven point reads, latency and data
        for (int v = 0; v < 6; v++) begin
            lo_qc.delete(); lo_qd.delete();
            issue(1'b0, VEC[v][0], 1'b0, 0, a0);
            idle_cycles(LAT + 2);
            chk(lo_qc.size() == 1, "R4 one rsp", lo_qc.size(), 1);
            if (lo_qc.size() == 1) begin
                chk(lo_qc[0] == a0 + LAT, "R4 latency", lo_qc[0] - a0, LAT);
                chk(lo_qd[0] == VEC[v][1], "R4 data", lo_qd[0], VEC[v][1]);
            end
        end

        // R2/R5: line fill of addresses 8..15 back to back
        lo_qc.delete(); lo_qd.delete();
        for (int i = 0; i < 8; i++) begin
            issue(1'b0, 8 + i, 1'b0, 0, a1);
            if (i == 0) a0 = a1;
        end
        chk(a1 - a0 == 7, "R2 no stall on line", a1 - a0, 7);
        idle_cycles(LAT + 2);
        chk(lo_qc.size() == 8, "R5 count", lo_qc.size(), 8);
        if (lo_qc.size() == 8) begin
            for (int i = 0; i < 8; i++) begin
                chk(lo_qc[i] == a0 + LAT + i, "R5 cycle", lo_qc[i] - a0, LAT + i);
                chk(lo_qd[i] == pat(8 + i), "R5 order/data", lo_qd[i], pat(8 + i));
            end
        end

        // R6/R8: repeat hit on bank 3 stalls, then completes
        lo_qc.delete(); lo_qd.delete();
        issue(1'b0, 3, 1'b0, 0, a0);
        issue(1'b0, 11, 1'b0, 0, a1);
        chk(a1 - a0 == LAT, "R6 busy window", a1 - a0, LAT);
        idle_cycles(LAT + 2);
        chk(lo_qc.size() == 2, "R8 rsp count", lo_qc.size(), 2);
        if (lo_qc.size() == 2) begin
            chk(lo_qc[1] == a1 + LAT, "R8 cycle", lo_qc[1] - a1, LAT);
            chk(lo_qd[1] == pat(11), "R8 data", lo_qd[1], pat(11));
        end

        // R7: write waits for busy bank, occupies it one cycle only
        lo_qc.delete(); lo_qd.delete();
        issue(1'b0, 4, 1'b0, 0, a0);
        issue(1'b0, 12, 1'b1, 8'h5A, w0);
        chk(w0 - a0 == LAT, "R7 write blocked", w0 - a0, LAT);
        issue(1'b0, 12, 1'b0, 0, a1);
        chk(a1 - w0 == 1, "R7 one-cycle occupancy", a1 - w0, 1);
        idle_cycles(LAT + 2);
        chk(lo_qc.size() == 2, "R7 rsp count", lo_qc.size(), 2);
        if (lo_qc.size() == 2) chk(lo_qd[1] == 8'h5A, "R7 written byte", lo_qd[1], 8'h5A);

        // R3/R9: high-order mapping
        issue(1'b1, 0, 1'b1, 8'h11, w0);
        issue(1'b1, 1, 1'b1, 8'h22, w1);
        chk(w1 - w0 == 1, "R7 hi write", w1 - w0, 1);
        issue(1'b1, 128, 1'b1, 8'h33, w0);
        issue(1'b1, 0, 1'b0, 0, a0);
        issue(1'b1, 1, 1'b0, 0, a1);
        chk(a1 - a0 == LAT, "R9 same bank stall", a1 - a0, LAT);
        issue(1'b1, 128, 1'b0, 0, a2);
        chk(a2 - a1 == 1, "R3 other bank", a2 - a1, 1);
        idle_cycles(LAT + 2);
        chk(hi_qc.size() == 3, "R3 rsp count", hi_qc.size(), 3);
        if (hi_qc.size() == 3) begin
            chk(hi_qd[0] == 8'h11, "R3 data0", hi_qd[0], 8'h11);
            chk(hi_qd[1] == 8'h22, "R9 data1", hi_qd[1], 8'h22);
            chk(hi_qd[2] == 8'h33, "R3 data2", hi_qd[2], 8'h33);
            chk(hi_qc[2] == a2 + LAT, "R3 latency", hi_qc[2] - a2, LAT);
        end

        report();
        $finish;
    end
endmodule